// File: doc/BRIEF.md
# Multi-Context Configuration Manager

This block keeps track of which operations are resident in each configuration context of a reconfigurable array. Each context holds a fixed number of operation slots. An operation is named by its context and its slot. Software issues three kinds of command on one command port: load an operation into a slot, drop an operation from a slot, or do nothing. A separate request port asks for one issue of an operation.

A single load engine streams configuration words toward the array, one wide word per accepted beat. Because it serves whichever context is named, an idle context can be filled while another context keeps computing. A load that arrives while the engine is busy waits in a one-entry holding register. The block also drives the active-context select of the array. Moving to another context costs one stall cycle. A request for an operation that is missing or only partly loaded stalls until that operation is fully configured.

Top module: `ctx_cfg_mgr`

## Requirements
- R1: After reset no slot holds an operation, the active context is 0, and busy, stall, set_reject, exec_go and cfg_out_valid are all low.
- R2: A load command (cmd_kind 1) accepted while the engine is idle starts streaming on the next cycle. The slot becomes usable after LOAD_BEATS beats, a beat being any cycle with cfg_src_valid high while streaming. cfg_out_last marks the final beat.
- R3: cfg_out_valid is high only while a load is streaming and cfg_src_valid is high. In those cycles cfg_out_data equals cfg_src_data, and cfg_out_ctx/cfg_out_slot name the slot being loaded.
- R4: A drop command (cmd_kind 2) clears the named slot at the next edge and leaves every other slot unchanged. A drop aimed at a slot that is loading has no effect. cmd_kind 0 and 3 do nothing.
- R5: exec_go is high in the same cycle as an exec_req that names a usable slot of the active context.
- R6: A request naming a slot that is empty or loading raises stall, does not change the active context, and keeps stalling until the load completes.
- R7: A request naming a usable slot of another context stalls for exactly one cycle. active_ctx takes the new value at that edge, and exec_go follows in the next cycle.
- R8: A load command that arrives while a load is streaming is held, and busy stays high while it is held. Any load command seen while busy is high is ignored. The held load starts one cycle after the running one completes.
- R9: A load command naming the active context in a cycle where exec_go is high is refused: set_reject pulses in that cycle and no load happens.
- R10: Streaming a load into a context that is not active proceeds in the same cycles as exec_go issues in the active context.
- R11: Loading a slot that already holds an operation makes that slot unusable from the first streaming cycle until the new load completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_kind | input | 2 | 0 none, 1 load, 2 drop, 3 none |
| cmd_ctx | input | CTX_W | Context named by the command |
| cmd_slot | input | SLOT_W | Slot named by the command |
| cfg_src_valid | input | 1 | Configuration source has a word this cycle |
| cfg_src_data | input | CFG_W | Configuration word from the source |
| cfg_out_valid | output | 1 | Configuration word to the array is valid |
| cfg_out_data | output | CFG_W | Configuration word to the array |
| cfg_out_ctx | output | CTX_W | Context being loaded |
| cfg_out_slot | output | SLOT_W | Slot being loaded |
| cfg_out_last | output | 1 | Current beat is the final one of the load |
| busy | output | 1 | A load is held; new load commands are ignored |
| set_reject | output | 1 | Load command refused this cycle |
| exec_req | input | 1 | Request for one issue of an operation |
| exec_ctx | input | CTX_W | Context of the requested operation |
| exec_slot | input | SLOT_W | Slot of the requested operation |
| exec_go | output | 1 | Requested operation issues this cycle |
| stall | output | 1 | Request cannot issue this cycle |
| active_ctx | output | CTX_W | Context selected on the array |

## Verification
On every cycle the assertions check four things. First, a request on a slot that is still streaming always stalls. Second, a slot whose last beat has just gone out does not stall the next cycle. Third, active_ctx changes only right after a stalled request. Fourth, busy rises only after a load command that was not refused, and cfg_out_valid never appears without source data. Other behaviour depends on the order of several commands, and only the bench's scenarios can show it: a held load waiting for the running one, an ignored load, a refusal, a drop on a loading slot, and a reload making a slot unusable. The bench follows these with a cycle model, both in directed sequences and under random traffic.

// File: rtl/ctx_cfg_pkg.sv
package ctx_cfg_pkg;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_LOAD = 2'd1,
      CMD_DROP = 2'd2,
      CMD_RSVD = 2'd3
   } cfg_cmd_e;

   function automatic int beat_width(input int beats);
      return (beats > 1) ? $clog2(beats) : 1;
   endfunction

endpackage

// File: rtl/ctx_cfg_table.sv
module ctx_cfg_table #(
   parameter int IDX_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_vld,
   input  logic [IDX_W-1:0]     start_idx,
   input  logic                 done_vld,
   input  logic [IDX_W-1:0]     done_idx,
   input  logic                 drop_vld,
   input  logic [IDX_W-1:0]     drop_idx,
   output logic [(1<<IDX_W)-1:0] valid_vec,
   output logic [(1<<IDX_W)-1:0] loading_vec
);

   localparam int ENTRIES = 1 << IDX_W;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(e);
      logic hit_start, hit_done, hit_drop;

      assign hit_start = start_vld && (start_idx == MY_IDX);
      assign hit_done  = done_vld  && (done_idx  == MY_IDX);
      assign hit_drop  = drop_vld  && (drop_idx  == MY_IDX);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_vec[e]   <= 1'b0;
            loading_vec[e] <= 1'b0;
         end else if (hit_start) begin
            valid_vec[e]   <= 1'b0;
            loading_vec[e] <= 1'b1;
         end else if (hit_done) begin
            valid_vec[e]   <= 1'b1;
            loading_vec[e] <= 1'b0;
         end else if (hit_drop && !loading_vec[e]) begin
            valid_vec[e]   <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ctx_cfg_loader.sv
module ctx_cfg_loader #(
   parameter int IDX_W      = 4,
   parameter int CFG_W      = 288,
   parameter int LOAD_BEATS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_vld,
   input  logic [IDX_W-1:0] take_idx,
   input  logic             src_valid,
   input  logic [CFG_W-1:0] src_data,
   output logic             out_valid,
   output logic [CFG_W-1:0] out_data,
   output logic [IDX_W-1:0] out_idx,
   output logic             out_last,
   output logic             busy,
   output logic             start_vld,
   output logic [IDX_W-1:0] start_idx,
   output logic             done_vld,
   output logic [IDX_W-1:0] done_idx
);

   localparam int BEAT_W = ctx_cfg_pkg::beat_width(LOAD_BEATS);
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(LOAD_BEATS - 1);

   logic              act_q;
   logic [IDX_W-1:0]  cur_q;
   logic [BEAT_W-1:0] beat_q;
   logic              hold_q;
   logic [IDX_W-1:0]  hold_idx_q;
   logic              beat_fire;
   logic              at_last;

   assign beat_fire = act_q && src_valid;
   assign at_last   = (beat_q == LAST_BEAT);

   assign start_vld = !act_q && (hold_q || take_vld);
   assign start_idx = hold_q ? hold_idx_q : take_idx;
   assign done_vld  = beat_fire && at_last;
   assign done_idx  = cur_q;

   assign out_valid = beat_fire;
   assign out_data  = src_data;
   assign out_idx   = cur_q;
   assign out_last  = act_q && at_last;
   assign busy      = hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q      <= 1'b0;
         cur_q      <= '0;
         beat_q     <= '0;
         hold_q     <= 1'b0;
         hold_idx_q <= '0;
      end else begin
         if (start_vld) begin
            act_q  <= 1'b1;
            cur_q  <= start_idx;
            beat_q <= '0;
         end else if (beat_fire) begin
            if (at_last) act_q  <= 1'b0;
            else         beat_q <= beat_q + 1'b1;
         end

         if (start_vld && hold_q) begin
            hold_q <= 1'b0;
         end else if (act_q && take_vld) begin
            hold_q     <= 1'b1;
            hold_idx_q <= take_idx;
         end
      end
   end

endmodule

// File: rtl/ctx_cfg_exec.sv
module ctx_cfg_exec #(
   parameter int CTX_W  = 2,
   parameter int SLOT_W = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req,
   input  logic [CTX_W-1:0]             req_ctx,
   input  logic [SLOT_W-1:0]            req_slot,
   input  logic [(1<<(CTX_W+SLOT_W))-1:0] valid_vec,
   input  logic [(1<<(CTX_W+SLOT_W))-1:0] loading_vec,
   output logic                         go,
   output logic                         stall,
   output logic [CTX_W-1:0]             active_ctx
);

   localparam int IDX_W = CTX_W + SLOT_W;

   logic [IDX_W-1:0] tgt;
   logic             tgt_ready;
   logic             same_ctx;
   logic [CTX_W-1:0] active_q;

   assign tgt       = {req_ctx, req_slot};
   assign tgt_ready = valid_vec[tgt] && !loading_vec[tgt];
   assign same_ctx  = (req_ctx == active_q);

   assign go         = req && tgt_ready && same_ctx;
   assign stall      = req && !go;
   assign active_ctx = active_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         active_q <= '0;
      else if (req && tgt_ready && !same_ctx)
         active_q <= req_ctx;
   end

endmodule

// File: rtl/ctx_cfg_mgr.sv
module ctx_cfg_mgr #(
   parameter int NUM_CTX    = 4,
   parameter int SLOTS      = 4,
   parameter int CFG_W      = 288,
   parameter int LOAD_BEATS = 8,
   localparam int CTX_W     = $clog2(NUM_CTX),
   localparam int SLOT_W    = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd_kind,
   input  logic [CTX_W-1:0]  cmd_ctx,
   input  logic [SLOT_W-1:0] cmd_slot,
   input  logic              cfg_src_valid,
   input  logic [CFG_W-1:0]  cfg_src_data,
   output logic              cfg_out_valid,
   output logic [CFG_W-1:0]  cfg_out_data,
   output logic [CTX_W-1:0]  cfg_out_ctx,
   output logic [SLOT_W-1:0] cfg_out_slot,
   output logic              cfg_out_last,
   output logic              busy,
   output logic              set_reject,
   input  logic              exec_req,
   input  logic [CTX_W-1:0]  exec_ctx,
   input  logic [SLOT_W-1:0] exec_slot,
   output logic              exec_go,
   output logic              stall,
   output logic [CTX_W-1:0]  active_ctx
);
   import ctx_cfg_pkg::*;

   localparam int IDX_W   = CTX_W + SLOT_W;
   localparam int ENTRIES = 1 << IDX_W;

   if (NUM_CTX < 2 || (NUM_CTX & (NUM_CTX - 1)) != 0) begin : g_bad_ctx
      $error("NUM_CTX must be a power of two, at least 2");
   end
   if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two, at least 2");
   end
   if (CFG_W < 1 || LOAD_BEATS < 1) begin : g_bad_load
      $error("CFG_W and LOAD_BEATS must be positive");
   end

   cfg_cmd_e         kind;
   logic             is_load;
   logic             take_vld;
   logic [IDX_W-1:0] cmd_idx;
   logic             start_vld, done_vld;
   logic [IDX_W-1:0] start_idx, done_idx, out_idx;
   logic [ENTRIES-1:0] valid_vec, loading_vec;

   assign kind       = cfg_cmd_e'(cmd_kind);
   assign cmd_idx    = {cmd_ctx, cmd_slot};
   assign is_load    = (kind == CMD_LOAD) && !busy;
   assign set_reject = is_load && exec_go && (cmd_ctx == active_ctx);
   assign take_vld   = is_load && !set_reject;

   ctx_cfg_loader #(
      .IDX_W      (IDX_W),
      .CFG_W      (CFG_W),
      .LOAD_BEATS (LOAD_BEATS)
   ) u_loader (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_vld  (take_vld),
      .take_idx  (cmd_idx),
      .src_valid (cfg_src_valid),
      .src_data  (cfg_src_data),
      .out_valid (cfg_out_valid),
      .out_data  (cfg_out_data),
      .out_idx   (out_idx),
      .out_last  (cfg_out_last),
      .busy      (busy),
      .start_vld (start_vld),
      .start_idx (start_idx),
      .done_vld  (done_vld),
      .done_idx  (done_idx)
   );

   assign cfg_out_ctx  = out_idx[IDX_W-1:SLOT_W];
   assign cfg_out_slot = out_idx[SLOT_W-1:0];

   ctx_cfg_table #(
      .IDX_W (IDX_W)
   ) u_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_vld   (start_vld),
      .start_idx   (start_idx),
      .done_vld    (done_vld),
      .done_idx    (done_idx),
      .drop_vld    (kind == CMD_DROP),
      .drop_idx    (cmd_idx),
      .valid_vec   (valid_vec),
      .loading_vec (loading_vec)
   );

   ctx_cfg_exec #(
      .CTX_W  (CTX_W),
      .SLOT_W (SLOT_W)
   ) u_exec (
      .clk         (clk),
      .rst_n       (rst_n),
      .req         (exec_req),
      .req_ctx     (exec_ctx),
      .req_slot    (exec_slot),
      .valid_vec   (valid_vec),
      .loading_vec (loading_vec),
      .go          (exec_go),
      .stall       (stall),
      .active_ctx  (active_ctx)
   );

endmodule

// File: rtl/ctx_cfg_mgr_chk.sv
module ctx_cfg_mgr_chk #(
   parameter int CTX_W  = 2,
   parameter int SLOT_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cmd_kind,
   input logic              cfg_src_valid,
   input logic              cfg_out_valid,
   input logic              cfg_out_last,
   input logic [CTX_W-1:0]  cfg_out_ctx,
   input logic [SLOT_W-1:0] cfg_out_slot,
   input logic              busy,
   input logic              set_reject,
   input logic              exec_req,
   input logic [CTX_W-1:0]  exec_ctx,
   input logic [SLOT_W-1:0] exec_slot,
   input logic              exec_go,
   input logic              stall,
   input logic [CTX_W-1:0]  active_ctx
);

   // R6
   loading_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_out_valid && exec_req && exec_ctx == cfg_out_ctx && exec_slot == cfg_out_slot)
      |-> stall);

   // R2
   loaded_usable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_out_valid && cfg_out_last)
      |=> !(exec_req && exec_ctx == $past(cfg_out_ctx) && exec_slot == $past(cfg_out_slot)
            && exec_ctx == active_ctx && stall));

   // R7
   switch_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(active_ctx) |-> $past(exec_req && stall && !exec_go));

   // R8
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_kind == 2'd1 && !set_reject));

   // R3
   out_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_out_valid |-> cfg_src_valid);

endmodule

bind ctx_cfg_mgr ctx_cfg_mgr_chk #(
   .CTX_W  (CTX_W),
   .SLOT_W (SLOT_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_kind      (cmd_kind),
   .cfg_src_valid (cfg_src_valid),
   .cfg_out_valid (cfg_out_valid),
   .cfg_out_last  (cfg_out_last),
   .cfg_out_ctx   (cfg_out_ctx),
   .cfg_out_slot  (cfg_out_slot),
   .busy          (busy),
   .set_reject    (set_reject),
   .exec_req      (exec_req),
   .exec_ctx      (exec_ctx),
   .exec_slot     (exec_slot),
   .exec_go       (exec_go),
   .stall         (stall),
   .active_ctx    (active_ctx)
);

// File: tb/ctx_cfg_mgr_tb.sv
module ctx_cfg_mgr_tb;

   localparam int NUM_CTX = 4;
   localparam int SLOTS   = 4;
   localparam int CFG_W   = 288;
   localparam int BEATS   = 8;
   localparam int CTX_W   = 2;
   localparam int SLOT_W  = 2;
   localparam int ENT     = NUM_CTX * SLOTS;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        cmd_kind = 2'd0;
   logic [CTX_W-1:0]  cmd_ctx = '0;
   logic [SLOT_W-1:0] cmd_slot = '0;
   logic              cfg_src_valid = 1'b0;
   logic [CFG_W-1:0]  cfg_src_data = '0;
   logic              cfg_out_valid;
   logic [CFG_W-1:0]  cfg_out_data;
   logic [CTX_W-1:0]  cfg_out_ctx;
   logic [SLOT_W-1:0] cfg_out_slot;
   logic              cfg_out_last;
   logic              busy, set_reject;
   logic              exec_req = 1'b0;
   logic [CTX_W-1:0]  exec_ctx = '0;
   logic [SLOT_W-1:0] exec_slot = '0;
   logic              exec_go, stall;
   logic [CTX_W-1:0]  active_ctx;

   always #10 clk = ~clk;

   ctx_cfg_mgr #(
      .NUM_CTX (NUM_CTX), .SLOTS (SLOTS), .CFG_W (CFG_W), .LOAD_BEATS (BEATS)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .cmd_kind (cmd_kind), .cmd_ctx (cmd_ctx),
      .cmd_slot (cmd_slot), .cfg_src_valid (cfg_src_valid), .cfg_src_data (cfg_src_data),
      .cfg_out_valid (cfg_out_valid), .cfg_out_data (cfg_out_data),
      .cfg_out_ctx (cfg_out_ctx), .cfg_out_slot (cfg_out_slot),
      .cfg_out_last (cfg_out_last), .busy (busy), .set_reject (set_reject),
      .exec_req (exec_req), .exec_ctx (exec_ctx), .exec_slot (exec_slot),
      .exec_go (exec_go), .stall (stall), .active_ctx (active_ctx)
   );

   int checks = 0;
   int errors = 0;

   // reference model state
   bit m_valid [ENT];
   bit m_load  [ENT];
   bit m_act, m_hold;
   int m_cur, m_beat, m_hold_idx, m_active;
   bit e_go, e_acc;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic bit ready_of(input int idx);
      return m_valid[idx] && !m_load[idx];
   endfunction

   task automatic compare();
      int tgt = int'(exec_ctx) * SLOTS + int'(exec_slot);
      bit e_busy, e_rej, e_ov, e_stall;
      e_go    = exec_req && ready_of(tgt) && (int'(exec_ctx) == m_active);
      e_stall = exec_req && !e_go;
      e_busy  = m_hold;
      e_rej   = (cmd_kind == 2'd1) && !e_busy && e_go && (int'(cmd_ctx) == m_active);
      e_acc   = (cmd_kind == 2'd1) && !e_busy && !e_rej;
      e_ov    = m_act && cfg_src_valid;
      chk("R5 exec_go", 64'(exec_go), 64'(e_go));
      chk("R6 stall", 64'(stall), 64'(e_stall));
      chk("R8 busy", 64'(busy), 64'(e_busy));
      chk("R9 set_reject", 64'(set_reject), 64'(e_rej));
      chk("R3 cfg_out_valid", 64'(cfg_out_valid), 64'(e_ov));
      chk("R7 active_ctx", 64'(active_ctx), 64'(m_active));
      if (e_ov) begin
         checks++;
         if (cfg_out_data !== cfg_src_data) begin
            errors++;
            $display("FAIL R3 cfg_out_data actual %0h expected %0h", cfg_out_data, cfg_src_data);
         end
         chk("R3 cfg_out_slot", 64'({cfg_out_ctx, cfg_out_slot}), 64'(m_cur));
         chk("R2 cfg_out_last", 64'(cfg_out_last), 64'(m_beat == BEATS - 1));
      end
   endtask

   task automatic model_update();
      int  cidx = int'(cmd_ctx) * SLOTS + int'(cmd_slot);
      int  tgt  = int'(exec_ctx) * SLOTS + int'(exec_slot);
      bit  was_act = m_act;
      bit  started = 1'b0;
      bit  from_hold = 1'b0;
      int  sidx = 0;
      bit  done = m_act && cfg_src_valid && (m_beat == BEATS - 1);
      if (exec_req && ready_of(tgt) && int'(exec_ctx) != m_active) m_active = int'(exec_ctx);
      if (!m_act && m_hold) begin started = 1'b1; sidx = m_hold_idx; from_hold = 1'b1; end
      else if (!m_act && e_acc) begin started = 1'b1; sidx = cidx; end
      if (cmd_kind == 2'd2 && !m_load[cidx]) m_valid[cidx] = 1'b0;
      if (done) begin m_valid[m_cur] = 1'b1; m_load[m_cur] = 1'b0; end
      if (started) begin m_valid[sidx] = 1'b0; m_load[sidx] = 1'b1; end
      if (started) begin
         m_act = 1'b1; m_cur = sidx; m_beat = 0;
         if (from_hold) m_hold = 1'b0;
      end else if (m_act && cfg_src_valid) begin
         if (m_beat == BEATS - 1) m_act = 1'b0;
         else m_beat++;
      end
      if (was_act && e_acc) begin m_hold = 1'b1; m_hold_idx = cidx; end
   endtask

   task automatic step(input logic [1:0] k, input int cc, input int cs, input bit sv,
                       input bit er, input int ec, input int es);
      @(negedge clk);
      cmd_kind      = k;
      cmd_ctx       = CTX_W'(cc);
      cmd_slot      = SLOT_W'(cs);
      cfg_src_valid = sv;
      for (int w = 0; w < CFG_W / 32; w++) cfg_src_data[w*32 +: 32] = $urandom();
      exec_req      = er;
      exec_ctx      = CTX_W'(ec);
      exec_slot     = SLOT_W'(es);
      #1;
      compare();
      @(posedge clk);
      model_update();
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int seed_init;
      int er, ec, es;
      seed_init = $urandom(32'd917);
      for (int i = 0; i < ENT; i++) begin m_valid[i] = 0; m_load[i] = 0; end
      m_act = 0; m_hold = 0; m_cur = 0; m_beat = 0; m_hold_idx = 0; m_active = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: idle state after reset
      @(negedge clk); #1;
      chk("R1 busy", 64'(busy), 64'd0);
      chk("R1 stall", 64'(stall), 64'd0);
      chk("R1 exec_go", 64'(exec_go), 64'd0);
      chk("R1 set_reject", 64'(set_reject), 64'd0);
      chk("R1 cfg_out_valid", 64'(cfg_out_valid), 64'd0);
      chk("R1 active_ctx", 64'(active_ctx), 64'd0);
      step(2'd0, 0, 0, 1, 1, 0, 0);
      chk("R1 empty slot stalls", 64'(stall), 64'd1);

      // R2: load ctx1 slot2 and stream it
      step(2'd1, 1, 2, 1, 0, 0, 0);
      for (int b = 0; b < BEATS; b++) step(2'd0, 0, 0, 1, 0, 0, 0);

      // R7: switch to ctx1 costs one stall cycle
      step(2'd0, 0, 0, 0, 1, 1, 2);
      chk("R7 switch stall", 64'(stall), 64'd1);
      step(2'd0, 0, 0, 0, 1, 1, 2);
      chk("R7 go after switch", 64'(exec_go), 64'd1);
      chk("R7 new active", 64'(active_ctx), 64'd1);

      // R9: load into the executing context is refused
      step(2'd1, 1, 0, 1, 1, 1, 2);
      chk("R9 refuse", 64'(set_reject), 64'd1);
      // R10: background load into ctx2 while ctx1 issues
      step(2'd1, 2, 1, 1, 1, 1, 2);
      step(2'd0, 0, 0, 1, 1, 1, 2);
      chk("R10 stream during issue", 64'(cfg_out_valid & exec_go), 64'd1);
      // R8: second load held, third ignored
      step(2'd1, 3, 3, 1, 1, 1, 2);
      step(2'd1, 0, 0, 1, 1, 1, 2);
      chk("R8 busy while held", 64'(busy), 64'd1);
      for (int i = 0; i < 16; i++) step(2'd0, 0, 0, 1, 1, 1, 2);

      // R4: drop clears the slot next cycle
      step(2'd2, 1, 2, 1, 1, 1, 2);
      step(2'd0, 0, 0, 1, 1, 1, 2);
      chk("R4 dropped slot stalls", 64'(stall), 64'd1);

      // R6: request on a loading slot stalls until complete
      step(2'd1, 1, 2, 1, 1, 1, 2);
      step(2'd0, 0, 0, 1, 1, 1, 2);
      chk("R6 loading stalls", 64'(stall), 64'd1);
      for (int i = 0; i < BEATS + 2; i++) step(2'd0, 0, 0, 1, 1, 1, 2);

      // R11: reloading a usable slot makes it unusable
      step(2'd1, 2, 1, 1, 0, 0, 0);
      step(2'd0, 0, 0, 1, 1, 2, 1);
      chk("R11 reload stalls", 64'(stall), 64'd1);
      for (int i = 0; i < BEATS + 2; i++) step(2'd0, 0, 0, 1, 0, 0, 0);

      // random traffic against the model
      er = 0; ec = 0; es = 0;
      for (int n = 0; n < 3000; n++) begin
         int r = $urandom % 8;
         logic [1:0] k = (r < 4) ? 2'd0 : (r < 6) ? 2'd1 : (r == 6) ? 2'd2 : 2'd3;
         if (($urandom % 4) == 0) begin
            er = $urandom % 2; ec = $urandom % NUM_CTX; es = $urandom % SLOTS;
         end
         step(k, $urandom % NUM_CTX, $urandom % SLOTS, ($urandom % 4) != 0, er[0], ec, es);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule